// File: doc/BRIEF.md
# Power State and Reset Source Controller

This block sequences the power states of a small chip and merges its reset sources into one system reset. It takes a power-on indication, a brownout comparator output and a shared external pin that can serve as an active-low reset. Alongside these it takes enable and routing bits, mode-request writes from the processor and a vector of interrupt requests. From these it drives a stretched system reset, a brownout interrupt, a sticky register of reset-cause flags and the gating enables for the processor clock, the peripheral clock, the main oscillator, the internal RC oscillator, the brownout detector and the analog comparators.

Four power states exist: run, idle, power-down and deep power-down. Software enters a low-power state by writing a mode request while running. Idle keeps peripherals clocked and leaves on any enabled interrupt. Both power-down depths stop the main oscillator and leave only on enabled interrupts that are also marked wake-capable. The deep depth additionally switches off the brownout detector and the comparators, so brownout has no effect there. Any reset returns the block to run.

The brownout detector can be disabled. When enabled, it either resets the chip or raises an interrupt. While the power-on sequence lasts, the shared pin acts as a reset whatever its enable bit says.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst` is 1. A power-on sets flag bit 0 of `rst_flags` and clears bits 1 and 2, except where their own cause is present in the same cycle.
- R2: `sys_rst` is 1 in every cycle in which a reset cause is present. It stays 1 for exactly HOLD (default 16) further clock cycles after the last cause goes away. It never rises without a cause.
- R3: A low `rst_pin_n` is a reset cause only when `rst_pin_en` is 1, or during the power-up phase. That phase starts at power-on and ends when the stretch that follows it ends. A pin reset sets flag bit 2.
- R4: With `bo_en`=1 and `bo_int_sel`=0, a high `bo_det` is a reset cause and sets flag bit 1.
- R5: With `bo_en`=1 and `bo_int_sel`=1, `bo_irq` follows `bo_det`, with no reset and no flag. With `bo_en`=0, `bo_det` has no effect.
- R6: Writing `flag_clr_wr`=1 clears each flag whose `flag_clr` bit is 1. A cause that sets a flag in the same cycle wins over the clear. Flags keep their value through resets other than power-on.
- R7: `pwr_state` encodes run=0, idle=1, power-down=2 and deep power-down=3. A `mode_wr` in run with no reset loads `mode_req` at the next clock edge. A `mode_wr` in any other state is ignored.
- R8: In idle, any request with `irq & irq_en` nonzero returns the state to run at the next clock edge.
- R9: In either power-down state, only a request with `irq & irq_en & wake_mask` nonzero returns the state to run. Enabled requests that are not wake-capable leave the state unchanged.
- R10: `cpu_clk_en` is 1 only in run. `periph_clk_en` and `osc_en` are 1 in run and idle. `cmp_en` is 0 only in deep power-down. `bod_en` equals `bo_en` outside deep power-down and is 0 inside it. `rcosc_en` equals `rc_is_sysclk` in run and idle; in either power-down state it equals `rc_is_sysclk & rtc_en`.
- R11: In deep power-down, `bo_det` causes no reset, no interrupt and no flag.
- R12: Any reset cause returns `pwr_state` to run at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| por_n | input | 1 | Power-on indication, low while supply comes up |
| bo_det | input | 1 | Brownout comparator, 1 while supply is below trip |
| rst_pin_n | input | 1 | Shared pin, active-low reset when enabled |
| rst_pin_en | input | 1 | Pin acts as reset when 1 |
| bo_en | input | 1 | Brownout detection enable |
| bo_int_sel | input | 1 | Brownout raises interrupt (1) or reset (0) |
| rc_is_sysclk | input | 1 | Internal RC oscillator is the system clock |
| rtc_en | input | 1 | Real-time timer enabled |
| mode_wr | input | 1 | Mode request write strobe |
| mode_req | input | 2 | Requested state code |
| irq | input | NIRQ | Interrupt requests |
| irq_en | input | NIRQ | Interrupt enables |
| wake_mask | input | NIRQ | Interrupts allowed to leave power-down |
| flag_clr_wr | input | 1 | Flag clear strobe |
| flag_clr | input | 3 | Write-1-to-clear mask for the flags |
| sys_rst | output | 1 | Stretched system reset |
| bo_irq | output | 1 | Brownout interrupt |
| rst_flags | output | 3 | Cause flags: bit0 power-on, bit1 brownout, bit2 pin |
| pwr_state | output | 2 | Current power state code |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| rcosc_en | output | 1 | Internal RC oscillator enable |
| bod_en | output | 1 | Brownout detector power enable |
| cmp_en | output | 1 | Analog comparator power enable |

## Verification
The reset path is driven by each cause alone: power-on, enabled pin, disabled pin, pin during power-up, and brownout in both routings and with detection off. These patterns separate a missing stretch, a wrong pin qualifier and wrong brownout routing. State transitions are tried with enabled requests that are not wake-capable, with disabled requests and with wake-capable requests in each low-power state. This tells the idle wake rule apart from the power-down wake rule. Flag clears are tried alone and in the same cycle as a set. Brownout is raised in deep power-down to show that it is ignored there.

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl #(
  parameter int NIRQ = 8,
  parameter int HOLD = 16
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            bo_det,
  input  logic            rst_pin_n,
  input  logic            rst_pin_en,
  input  logic            bo_en,
  input  logic            bo_int_sel,
  input  logic            rc_is_sysclk,
  input  logic            rtc_en,
  input  logic            mode_wr,
  input  logic [1:0]      mode_req,
  input  logic [NIRQ-1:0] irq,
  input  logic [NIRQ-1:0] irq_en,
  input  logic [NIRQ-1:0] wake_mask,
  input  logic            flag_clr_wr,
  input  logic [2:0]      flag_clr,
  output logic            sys_rst,
  output logic            bo_irq,
  output logic [2:0]      rst_flags,
  output logic [1:0]      pwr_state,
  output logic            cpu_clk_en,
  output logic            periph_clk_en,
  output logic            osc_en,
  output logic            rcosc_en,
  output logic            bod_en,
  output logic            cmp_en
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_IDLE = 2'd1, ST_PD = 2'd2, ST_DPD = 2'd3} pstate_t;

  pstate_t       st;
  logic [CW-1:0] cnt;
  logic          pu;
  logic [2:0]    flags;

  logic deep, asleep, bo_act, por_c, bo_c, pin_c, cause, wake_idle, wake_pd;

  assign deep      = (st == ST_DPD);
  assign asleep    = st[1];
  assign bo_act    = bo_det & bo_en & ~deep;
  assign por_c     = ~por_n;
  assign bo_c      = bo_act & ~bo_int_sel;
  assign pin_c     = ~rst_pin_n & (rst_pin_en | pu);
  assign cause     = por_c | bo_c | pin_c;
  assign wake_idle = |(irq & irq_en);
  assign wake_pd   = |(irq & irq_en & wake_mask);

  assign sys_rst       = cause | (cnt != '0);
  assign bo_irq        = bo_act & bo_int_sel;
  assign rst_flags     = flags;
  assign pwr_state     = st;
  assign cpu_clk_en    = (st == ST_RUN);
  assign periph_clk_en = ~asleep;
  assign osc_en        = ~asleep;
  assign rcosc_en      = asleep ? (rc_is_sysclk & rtc_en) : rc_is_sysclk;
  assign bod_en        = bo_en & ~deep;
  assign cmp_en        = ~deep;

  always_ff @(posedge clk) begin
    if (cause)          cnt <= HOLD_V;
    else if (cnt != '0) cnt <= cnt - 1'b1;

    if (por_c)                      pu <= 1'b1;
    else if (!cause && cnt <= 1)    pu <= 1'b0;

    if (por_c) flags <= {pin_c, bo_c, 1'b1};
    else       flags <= (flags & ~(flag_clr_wr ? flag_clr : 3'b000)) | {pin_c, bo_c, 1'b0};

    if (sys_rst) st <= ST_RUN;
    else begin
      case (st)
        ST_RUN:  if (mode_wr) st <= pstate_t'(mode_req);
        ST_IDLE: if (wake_idle) st <= ST_RUN;
        default: if (wake_pd) st <= ST_RUN;
      endcase
    end
  end
endmodule

module pwr_rst_ctrl_chk #(
  parameter int NIRQ = 8
) (
  input logic            clk,
  input logic            por_n,
  input logic            bo_det,
  input logic            rst_pin_n,
  input logic            mode_wr,
  input logic [NIRQ-1:0] irq,
  input logic [NIRQ-1:0] irq_en,
  input logic [NIRQ-1:0] wake_mask,
  input logic            flag_clr_wr,
  input logic [2:0]      flag_clr,
  input logic            sys_rst,
  input logic            bo_irq,
  input logic [2:0]      rst_flags,
  input logic [1:0]      pwr_state,
  input logic            cpu_clk_en,
  input logic            bod_en,
  input logic            cmp_en
);
  a_r2_rst_needs_cause: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst) |-> (!rst_pin_n || bo_det));

  a_r7_idle_from_run: assert property (@(posedge clk) disable iff (!por_n)
    (pwr_state == 2'd1 && $past(pwr_state) != 2'd1) |-> ($past(pwr_state) == 2'd0 && $past(mode_wr)));

  a_r9_pd_needs_wake: assert property (@(posedge clk) disable iff (!por_n)
    (pwr_state[1] && !sys_rst && !(|(irq & irq_en & wake_mask))) |=> (pwr_state == $past(pwr_state)));

  a_r10_cpu_gate: assert property (@(posedge clk) disable iff (!por_n)
    (pwr_state != 2'd0) |-> !cpu_clk_en);

  a_r11_deep_quiet: assert property (@(posedge clk) disable iff (!por_n)
    (pwr_state == 2'd3) |-> (!bo_irq && !bod_en && !cmp_en));

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (rst_flags[0] && !(flag_clr_wr && flag_clr[0])) |=> rst_flags[0]);
endmodule

bind pwr_rst_ctrl pwr_rst_ctrl_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .por_n(por_n), .bo_det(bo_det), .rst_pin_n(rst_pin_n), .mode_wr(mode_wr),
  .irq(irq), .irq_en(irq_en), .wake_mask(wake_mask), .flag_clr_wr(flag_clr_wr),
  .flag_clr(flag_clr), .sys_rst(sys_rst), .bo_irq(bo_irq), .rst_flags(rst_flags),
  .pwr_state(pwr_state), .cpu_clk_en(cpu_clk_en), .bod_en(bod_en), .cmp_en(cmp_en)
);

// File: tb/pwr_rst_ctrl_bench.sv
module pwr_rst_ctrl_bench;
  localparam int NIRQ = 8;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por_n = 1'b0, bo_det = 1'b0, rst_pin_n = 1'b1, rst_pin_en = 1'b0;
  logic bo_en = 1'b0, bo_int_sel = 1'b0, rc_is_sysclk = 1'b0, rtc_en = 1'b0;
  logic mode_wr = 1'b0, flag_clr_wr = 1'b0;
  logic [1:0] mode_req = 2'd0;
  logic [2:0] flag_clr = 3'd0;
  logic [NIRQ-1:0] irq = '0, irq_en = '0, wake_mask = '0;

  logic sys_rst, bo_irq, cpu_clk_en, periph_clk_en, osc_en, rcosc_en, bod_en, cmp_en;
  logic [2:0] rst_flags;
  logic [1:0] pwr_state;

  pwr_rst_ctrl #(.NIRQ(NIRQ), .HOLD(HOLD)) u_pwr_rst_ctrl (
    .clk(clk), .por_n(por_n), .bo_det(bo_det), .rst_pin_n(rst_pin_n), .rst_pin_en(rst_pin_en),
    .bo_en(bo_en), .bo_int_sel(bo_int_sel), .rc_is_sysclk(rc_is_sysclk), .rtc_en(rtc_en),
    .mode_wr(mode_wr), .mode_req(mode_req), .irq(irq), .irq_en(irq_en), .wake_mask(wake_mask),
    .flag_clr_wr(flag_clr_wr), .flag_clr(flag_clr), .sys_rst(sys_rst), .bo_irq(bo_irq),
    .rst_flags(rst_flags), .pwr_state(pwr_state), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en), .rcosc_en(rcosc_en), .bod_en(bod_en),
    .cmp_en(cmp_en)
  );

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0, m_st = 0;
  bit m_pu = 1'b0, m_started = 1'b0;
  logic [2:0] m_fl = 3'd0;

  function automatic bit m_boact();
    return bo_det && bo_en && (m_st != 3);
  endfunction
  function automatic bit m_pinc();
    return !rst_pin_n && (rst_pin_en || m_pu);
  endfunction
  function automatic bit m_cause();
    return !por_n || (m_boact() && !bo_int_sel) || m_pinc();
  endfunction
  function automatic bit m_rst();
    return m_cause() || (m_cnt > 0);
  endfunction

  always @(posedge clk) begin
    bit c, r, pc, bc;
    c  = m_cause();
    r  = m_rst();
    pc = m_pinc();
    bc = m_boact() && !bo_int_sel;
    if (!por_n) m_fl = {pc, bc, 1'b1};
    else m_fl = (m_fl & ~(flag_clr_wr ? flag_clr : 3'b000)) | {pc, bc, 1'b0};
    if (!por_n) m_pu = 1'b1;
    else if (!c && m_cnt <= 1) m_pu = 1'b0;
    if (r) m_st = 0;
    else if (m_st == 0) begin if (mode_wr) m_st = int'(mode_req); end
    else if (m_st == 1) begin if ((irq & irq_en) != 0) m_st = 0; end
    else if ((irq & irq_en & wake_mask) != 0) m_st = 0;
    if (c) m_cnt = HOLD;
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
    m_started = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    bit sl;
    sl = (m_st >= 2);
    chk(sys_rst === m_rst(), "R2 sys_rst", int'(sys_rst), int'(m_rst()));
    chk(rst_flags === m_fl, "R6 rst_flags", int'(rst_flags), int'(m_fl));
    chk(pwr_state === 2'(m_st), "R7 pwr_state", int'(pwr_state), m_st);
    chk(bo_irq === (m_boact() && bo_int_sel), "R5 bo_irq", int'(bo_irq), int'(m_boact() && bo_int_sel));
    chk({cpu_clk_en, periph_clk_en, osc_en, rcosc_en, bod_en, cmp_en} ===
        {m_st == 0, !sl, !sl, sl ? (rc_is_sysclk && rtc_en) : rc_is_sysclk, bo_en && m_st != 3, m_st != 3},
        "R10 gating", int'({cpu_clk_en, periph_clk_en, osc_en, rcosc_en, bod_en, cmp_en}), 0);
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      if (m_started) cmp_all();
    end
  endtask

  task automatic settle();
    while (m_rst()) tick();
  endtask

  task automatic wr_mode(input logic [1:0] m);
    mode_req = m; mode_wr = 1'b1;
    tick();
    mode_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(4);
    chk(sys_rst === 1'b1, "R1 rst during power-on", int'(sys_rst), 1);
    chk(rst_flags === 3'b001, "R1 power-on flag", int'(rst_flags), 1);
    chk(pwr_state === 2'd0, "R12 run after reset", int'(pwr_state), 0);
    por_n = 1'b1;
    tick(HOLD - 1);
    chk(sys_rst === 1'b1, "R2 stretch still held", int'(sys_rst), 1);
    tick();
    chk(sys_rst === 1'b0, "R2 stretch ends after HOLD", int'(sys_rst), 0);

    rst_pin_n = 1'b0;
    tick(3);
    chk(sys_rst === 1'b0, "R3 pin ignored when disabled", int'(sys_rst), 0);
    rst_pin_en = 1'b1;
    #0;
    chk(sys_rst === 1'b1, "R3 pin reset when enabled", int'(sys_rst), 1);
    tick();
    chk(rst_flags === 3'b101, "R3 pin flag set", int'(rst_flags), 5);
    rst_pin_n = 1'b1; rst_pin_en = 1'b0;
    settle();

    por_n = 1'b0;
    tick(2);
    por_n = 1'b1; rst_pin_n = 1'b0;
    tick(20);
    chk(sys_rst === 1'b1, "R3 pin forced during power-up", int'(sys_rst), 1);
    chk(rst_flags === 3'b101, "R1 power-on clears others, pin sets bit 2", int'(rst_flags), 5);
    rst_pin_n = 1'b1;
    tick(HOLD);
    chk(sys_rst === 1'b0, "R2 release after pin", int'(sys_rst), 0);

    flag_clr_wr = 1'b1; flag_clr = 3'b111;
    tick();
    flag_clr_wr = 1'b0;
    chk(rst_flags === 3'b000, "R6 write-1 clear", int'(rst_flags), 0);
    rst_pin_en = 1'b1; rst_pin_n = 1'b0; flag_clr_wr = 1'b1; flag_clr = 3'b100;
    tick();
    flag_clr_wr = 1'b0; rst_pin_n = 1'b1; rst_pin_en = 1'b0;
    chk(rst_flags === 3'b100, "R6 set wins over clear", int'(rst_flags), 4);
    settle();
    chk(rst_flags === 3'b100, "R6 flag kept through pin reset", int'(rst_flags), 4);

    bo_det = 1'b1;
    tick(2);
    chk(sys_rst === 1'b0 && bo_irq === 1'b0, "R5 brownout off has no effect", int'({sys_rst, bo_irq}), 0);
    bo_en = 1'b1;
    tick();
    chk(sys_rst === 1'b1, "R4 brownout reset", int'(sys_rst), 1);
    chk(rst_flags[1] === 1'b1, "R4 brownout flag", int'(rst_flags), 6);
    bo_det = 1'b0;
    settle();
    flag_clr_wr = 1'b1; flag_clr = 3'b111;
    tick();
    flag_clr_wr = 1'b0;
    bo_int_sel = 1'b1; bo_det = 1'b1;
    tick(2);
    chk(bo_irq === 1'b1 && sys_rst === 1'b0, "R5 brownout interrupt", int'({bo_irq, sys_rst}), 2);
    chk(rst_flags === 3'b000, "R5 no flag on interrupt route", int'(rst_flags), 0);
    bo_det = 1'b0;
    tick();

    irq_en = 8'h0F; wake_mask = 8'h01;
    wr_mode(2'd1);
    chk(pwr_state === 2'd1, "R7 enter idle", int'(pwr_state), 1);
    chk(cpu_clk_en === 1'b0 && periph_clk_en === 1'b1, "R10 idle gating", int'({cpu_clk_en, periph_clk_en}), 1);
    wr_mode(2'd2);
    chk(pwr_state === 2'd1, "R7 write ignored outside run", int'(pwr_state), 1);
    irq = 8'h10;
    tick(2);
    chk(pwr_state === 2'd1, "R8 disabled irq keeps idle", int'(pwr_state), 1);
    irq = 8'h02;
    tick();
    irq = '0;
    chk(pwr_state === 2'd0, "R8 enabled irq wakes idle", int'(pwr_state), 0);

    rc_is_sysclk = 1'b1; rtc_en = 1'b1;
    wr_mode(2'd2);
    chk(pwr_state === 2'd2, "R7 enter power-down", int'(pwr_state), 2);
    chk(osc_en === 1'b0 && rcosc_en === 1'b1 && bod_en === 1'b1, "R10 power-down gating",
        int'({osc_en, rcosc_en, bod_en}), 3);
    rtc_en = 1'b0;
    tick();
    chk(rcosc_en === 1'b0, "R10 RC off without timer", int'(rcosc_en), 0);
    irq = 8'h02;
    tick(2);
    chk(pwr_state === 2'd2, "R9 non-wake irq ignored", int'(pwr_state), 2);
    irq = 8'h01;
    tick();
    irq = '0;
    chk(pwr_state === 2'd0, "R9 wake irq exits power-down", int'(pwr_state), 0);

    bo_int_sel = 1'b0;
    wr_mode(2'd3);
    chk(pwr_state === 2'd3 && cmp_en === 1'b0 && bod_en === 1'b0, "R10 deep gating",
        int'({pwr_state, cmp_en, bod_en}), 12);
    bo_det = 1'b1;
    tick(3);
    chk(sys_rst === 1'b0 && bo_irq === 1'b0 && rst_flags === 3'b000, "R11 brownout ignored in deep",
        int'({sys_rst, bo_irq, rst_flags}), 0);
    bo_det = 1'b0;
    rst_pin_en = 1'b1; rst_pin_n = 1'b0;
    tick();
    rst_pin_n = 1'b1;
    chk(pwr_state === 2'd0, "R12 reset returns to run", int'(pwr_state), 0);
    settle();
    tick(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule